// File: doc/BRIEF.md
# Prioritized Exception Entry and Vectoring Unit

This block sits beside a processor's fetch and retire logic and decides when control must be diverted to an exception handler. Six request sources feed it. Two are urgent, non-maskable levels: system reset and machine check. Two are synchronous instruction flags: alignment and floating-point. The last two are maskable asynchronous levels: external interrupt and decrementer expiry. In any cycle where at least one request is accepted, the unit selects the single most urgent one. In that same cycle it raises a redirect strobe together with the handler address. That address comes from a table of 32 slots spaced 256 bytes apart, at a low or a high base.

At the next clock edge the unit saves the interrupted program counter and the whole machine state word into two save/restore registers. It then drops the external-enable bit and forces supervisor privilege. A return pulse reverses this: it redirects to the saved program counter and reloads the machine state from the second save register. A separate load strobe lets the pipeline write the machine state word directly. Asynchronous requests are expected to be held by their sources until they are serviced. Synchronous flags count only in a cycle where the instruction-valid input is high.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the machine state word, both save registers and cause_idx are zero, and redirect is low.
- R2: Among the accepted requests the one taken follows a fixed order, most urgent first: system reset, machine check, alignment, floating-point, external interrupt, decrementer.
- R3: flag_align and flag_fp are accepted only in a cycle where ins_valid is 1. Without ins_valid they cause no redirect.
- R4: req_ext and req_dec are accepted only while machine state bit 0 (external enable) is 1. req_sysrst and req_mcheck are accepted regardless of that bit.
- R5: When an exception is taken, redirect rises in that same cycle. cause_idx gives the slot number, and redirect_pc equals table base + slot × 0x100. The slot numbers are: reset 1, machine check 2, alignment 6, floating-point 8, external 5, decrementer 9.
- R6: The table base is 0x00000000 when machine state bit 2 is 0 and 0xFFF00000 when it is 1.
- R7: At the edge that ends an exception cycle, srr0_q takes cur_pc and srr1_q takes the full machine state word.
- R8: At that same edge, machine state bit 0 (external enable) and bit 1 (privilege, 0 = supervisor) are cleared, and all other bits are kept.
- R9: A ret_pulse cycle with no accepted exception raises redirect with cause_idx 0 and redirect_pc equal to srr0_q. The machine state word then takes srr1_q at the following edge.
- R10: An accepted exception overrides ret_pulse and msr_load. ret_pulse overrides msr_load. A lone msr_load writes msr_load_val into the machine state word at the next edge. redirect_pc is 0 when redirect is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_sysrst | input | 1 | System reset request, level |
| req_mcheck | input | 1 | Machine check request, level |
| ins_valid | input | 1 | Qualifies the synchronous flags |
| flag_align | input | 1 | Alignment fault of the current instruction |
| flag_fp | input | 1 | Floating-point fault of the current instruction |
| req_ext | input | 1 | External interrupt request, level |
| req_dec | input | 1 | Decrementer expiry request, level |
| cur_pc | input | 32 | Program counter to save on entry |
| ret_pulse | input | 1 | Return-from-exception strobe |
| msr_load | input | 1 | Direct write strobe for the machine state word |
| msr_load_val | input | 8 | Value for a direct write |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target address |
| cause_idx | output | 5 | Slot number of the taken exception, 0 for a return or idle |
| msr_q | output | 8 | Machine state word (bit0 ext enable, bit1 user, bit2 high table, bit3 instr xlate, bit4 data xlate, bit5 recoverable, bit6 little-endian, bit7 spare) |
| srr0_q | output | 32 | Saved program counter |
| srr1_q | output | 8 | Saved machine state word |

## Verification
The hardest case to reach is a maskable request arriving while external enable is set and the high table is selected. Every exception clears the enable bit, so it takes effort to get back into that state. The stimulus handles this by issuing msr_load and ret_pulse often. These restore saved words whose enable and table bits were set earlier, so ext and dec requests are tried against both table bases and both enable states. Directed sequences also pile several requests into one cycle, together with ret_pulse and msr_load, to exercise the ordering rules.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int unsigned NSRC = 6;

   typedef enum logic [2:0] {
      SRC_RST = 3'd0,
      SRC_MCK = 3'd1,
      SRC_ALN = 3'd2,
      SRC_FPU = 3'd3,
      SRC_EXT = 3'd4,
      SRC_DEC = 3'd5
   } exc_src_e;

   localparam int MSR_XEN = 0;
   localparam int MSR_USR = 1;
   localparam int MSR_HIT = 2;
   localparam int MSR_ITR = 3;
   localparam int MSR_DTR = 4;
   localparam int MSR_RCV = 5;
   localparam int MSR_LEN = 6;
   localparam int MSR_MIN_W = 7;
endpackage

// File: rtl/exc_prio_select.sv
module exc_prio_select #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   generate
      if (N < 1) begin : g_bad_n
         $error("exc_prio_select: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_lane
         if (i == 0) begin : g_top
            assign gnt[i] = req[i];
         end else begin : g_rest
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

   assign any = |req;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          VEC_COUNT  = 32,
   parameter int unsigned          STRIDE_LG2 = 8,
   parameter logic [ADDR_W-1:0]    LOW_BASE   = '0,
   parameter logic [ADDR_W-1:0]    HIGH_BASE  = 32'hFFF0_0000
) (
   input  logic                          hi_sel,
   input  logic [$clog2(VEC_COUNT)-1:0]  idx,
   output logic [ADDR_W-1:0]             addr
);
   localparam int unsigned IDX_W  = $clog2(VEC_COUNT);
   localparam int unsigned SPAN_W = IDX_W + STRIDE_LG2;
   localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'((64'd1 << SPAN_W) - 64'd1);
   localparam bit BASES_ALIGNED =
      ((LOW_BASE & SPAN_MASK) == '0) && ((HIGH_BASE & SPAN_MASK) == '0);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;

   assign base   = hi_sel ? HIGH_BASE : LOW_BASE;
   assign offset = ADDR_W'(idx) << STRIDE_LG2;

   generate
      if (SPAN_W > ADDR_W) begin : g_bad_span
         $error("exc_vector_gen: table span exceeds address width");
      end
      if (BASES_ALIGNED) begin : g_or_join
         assign addr = base | offset;
      end else begin : g_add_join
         assign addr = base + offset;
      end
   endgenerate
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
   import exc_entry_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MSR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              ret,
   input  logic              ld,
   input  logic [MSR_W-1:0]  ld_val,
   input  logic [ADDR_W-1:0] pc,
   output logic [MSR_W-1:0]  msr_q,
   output logic [ADDR_W-1:0] srr0_q,
   output logic [MSR_W-1:0]  srr1_q
);
   localparam logic [MSR_W-1:0] ENTRY_KEEP =
      ~((MSR_W'(1) << MSR_XEN) | (MSR_W'(1) << MSR_USR));

   logic [MSR_W-1:0] msr_d;

   generate
      if (MSR_W < MSR_MIN_W) begin : g_bad_msr
         $error("exc_state_regs: machine state word too narrow");
      end
   endgenerate

   always_comb begin
      if (take)      msr_d = msr_q & ENTRY_KEEP;
      else if (ret)  msr_d = srr1_q;
      else if (ld)   msr_d = ld_val;
      else           msr_d = msr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msr_q  <= '0;
         srr0_q <= '0;
         srr1_q <= '0;
      end else begin
         msr_q <= msr_d;
         if (take) begin
            srr0_q <= pc;
            srr1_q <= msr_q;
         end
      end
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       MSR_W      = 8,
   parameter int unsigned       VEC_COUNT  = 32,
   parameter int unsigned       STRIDE_LG2 = 8,
   parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFFF0_0000,
   parameter int unsigned       IDX_RST    = 1,
   parameter int unsigned       IDX_MCK    = 2,
   parameter int unsigned       IDX_ALN    = 6,
   parameter int unsigned       IDX_FPU    = 8,
   parameter int unsigned       IDX_EXT    = 5,
   parameter int unsigned       IDX_DEC    = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_sysrst,
   input  logic                          req_mcheck,
   input  logic                          ins_valid,
   input  logic                          flag_align,
   input  logic                          flag_fp,
   input  logic                          req_ext,
   input  logic                          req_dec,
   input  logic [ADDR_W-1:0]             cur_pc,
   input  logic                          ret_pulse,
   input  logic                          msr_load,
   input  logic [MSR_W-1:0]              msr_load_val,
   output logic                          redirect,
   output logic [ADDR_W-1:0]             redirect_pc,
   output logic [$clog2(VEC_COUNT)-1:0]  cause_idx,
   output logic [MSR_W-1:0]              msr_q,
   output logic [ADDR_W-1:0]             srr0_q,
   output logic [MSR_W-1:0]              srr1_q
);
   localparam int unsigned IDX_W = $clog2(VEC_COUNT);

   function automatic logic [IDX_W-1:0] slot_of(input int unsigned s);
      case (s)
         SRC_RST: slot_of = IDX_W'(IDX_RST);
         SRC_MCK: slot_of = IDX_W'(IDX_MCK);
         SRC_ALN: slot_of = IDX_W'(IDX_ALN);
         SRC_FPU: slot_of = IDX_W'(IDX_FPU);
         SRC_EXT: slot_of = IDX_W'(IDX_EXT);
         default: slot_of = IDX_W'(IDX_DEC);
      endcase
   endfunction

   generate
      if (IDX_RST == 0 || IDX_MCK == 0 || IDX_ALN == 0 ||
          IDX_FPU == 0 || IDX_EXT == 0 || IDX_DEC == 0) begin : g_bad_zero
         $error("exc_entry_unit: slot 0 is reserved for returns");
      end
      if (IDX_RST >= VEC_COUNT || IDX_MCK >= VEC_COUNT || IDX_ALN >= VEC_COUNT ||
          IDX_FPU >= VEC_COUNT || IDX_EXT >= VEC_COUNT || IDX_DEC >= VEC_COUNT) begin : g_bad_idx
         $error("exc_entry_unit: slot number outside the table");
      end
      if ((1 << IDX_W) != VEC_COUNT) begin : g_bad_cnt
         $error("exc_entry_unit: table size must be a power of two");
      end
   endgenerate

   logic [NSRC-1:0]   req_vec;
   logic [NSRC-1:0]   gnt_vec;
   logic              take;
   logic              do_ret;
   logic [IDX_W-1:0]  slot;
   logic [ADDR_W-1:0] vec_addr;
   logic              ext_en;

   assign ext_en = msr_q[MSR_XEN];

   always_comb begin
      req_vec          = '0;
      req_vec[SRC_RST] = req_sysrst;
      req_vec[SRC_MCK] = req_mcheck;
      req_vec[SRC_ALN] = ins_valid & flag_align;
      req_vec[SRC_FPU] = ins_valid & flag_fp;
      req_vec[SRC_EXT] = ext_en & req_ext;
      req_vec[SRC_DEC] = ext_en & req_dec;
   end

   exc_prio_select #(.N(NSRC)) u_prio (
      .req (req_vec),
      .gnt (gnt_vec),
      .any (take)
   );

   always_comb begin
      slot = '0;
      for (int s = 0; s < int'(NSRC); s++) begin
         if (gnt_vec[s]) slot = slot | slot_of(s);
      end
   end

   exc_vector_gen #(
      .ADDR_W     (ADDR_W),
      .VEC_COUNT  (VEC_COUNT),
      .STRIDE_LG2 (STRIDE_LG2),
      .LOW_BASE   ('0),
      .HIGH_BASE  (HIGH_BASE)
   ) u_vec (
      .hi_sel (msr_q[MSR_HIT]),
      .idx    (slot),
      .addr   (vec_addr)
   );

   assign do_ret = ret_pulse & ~take;

   exc_state_regs #(
      .ADDR_W (ADDR_W),
      .MSR_W  (MSR_W)
   ) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .ret    (do_ret),
      .ld     (msr_load),
      .ld_val (msr_load_val),
      .pc     (cur_pc),
      .msr_q  (msr_q),
      .srr0_q (srr0_q),
      .srr1_q (srr1_q)
   );

   always_comb begin
      redirect    = take | do_ret;
      cause_idx   = take ? slot : '0;
      if (take)        redirect_pc = vec_addr;
      else if (do_ret) redirect_pc = srr0_q;
      else             redirect_pc = '0;
   end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       MSR_W      = 8,
   parameter int unsigned       VEC_COUNT  = 32,
   parameter int unsigned       STRIDE_LG2 = 8,
   parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFFF0_0000,
   parameter int unsigned       IDX_RST    = 1,
   parameter int unsigned       IDX_MCK    = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_sysrst,
   input logic                          req_mcheck,
   input logic                          ins_valid,
   input logic                          flag_align,
   input logic                          flag_fp,
   input logic                          req_ext,
   input logic                          req_dec,
   input logic [ADDR_W-1:0]             cur_pc,
   input logic                          ret_pulse,
   input logic                          redirect,
   input logic [ADDR_W-1:0]             redirect_pc,
   input logic [$clog2(VEC_COUNT)-1:0]  cause_idx,
   input logic [MSR_W-1:0]              msr_q,
   input logic [ADDR_W-1:0]             srr0_q,
   input logic [MSR_W-1:0]              srr1_q
);
   logic entry;
   assign entry = redirect && (cause_idx != '0);

   assert_rst_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_sysrst |-> (redirect && cause_idx == ($clog2(VEC_COUNT))'(IDX_RST)));

   assert_mck_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mcheck && !req_sysrst) |-> (redirect && cause_idx == ($clog2(VEC_COUNT))'(IDX_MCK)));

   assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!msr_q[0] && !req_sysrst && !req_mcheck && !(ins_valid && (flag_align || flag_fp))
       && !ret_pulse) |-> !redirect);

   assert_sync_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid && !req_sysrst && !req_mcheck && !req_ext && !req_dec && !ret_pulse)
      |-> !redirect);

   assert_vector_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      entry |-> (redirect_pc ==
                 ((msr_q[2] ? HIGH_BASE : ADDR_W'(0)) + (ADDR_W'(cause_idx) << STRIDE_LG2))));

   assert_save_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (srr0_q == $past(cur_pc) && srr1_q == $past(msr_q)));

   assert_entry_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (!msr_q[0] && !msr_q[1] && msr_q[MSR_W-1:2] == $past(msr_q[MSR_W-1:2])));

   assert_return_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && cause_idx == '0) |-> (redirect_pc == srr0_q));

   assert_return_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && cause_idx == '0) |=> (msr_q == $past(srr1_q)));

   assert_idle_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |-> (redirect_pc == '0 && cause_idx == '0));
endmodule

bind exc_entry_unit exc_entry_checker #(
   .ADDR_W     (ADDR_W),
   .MSR_W      (MSR_W),
   .VEC_COUNT  (VEC_COUNT),
   .STRIDE_LG2 (STRIDE_LG2),
   .HIGH_BASE  (HIGH_BASE),
   .IDX_RST    (IDX_RST),
   .IDX_MCK    (IDX_MCK)
) u_exc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_sysrst  (req_sysrst),
   .req_mcheck  (req_mcheck),
   .ins_valid   (ins_valid),
   .flag_align  (flag_align),
   .flag_fp     (flag_fp),
   .req_ext     (req_ext),
   .req_dec     (req_dec),
   .cur_pc      (cur_pc),
   .ret_pulse   (ret_pulse),
   .redirect    (redirect),
   .redirect_pc (redirect_pc),
   .cause_idx   (cause_idx),
   .msr_q       (msr_q),
   .srr0_q      (srr0_q),
   .srr1_q      (srr1_q)
);

// File: tb/exc_entry_unit_test.sv
`timescale 1ns/1ps
module exc_entry_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_sysrst = 0, req_mcheck = 0, ins_valid = 0, flag_align = 0, flag_fp = 0;
   logic        req_ext = 0, req_dec = 0, ret_pulse = 0, msr_load = 0;
   logic [31:0] cur_pc = '0;
   logic [7:0]  msr_load_val = '0;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic [4:0]  cause_idx;
   logic [7:0]  msr_q, srr1_q;
   logic [31:0] srr0_q;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   // reference state
   logic [7:0]  m_msr = '0, m_srr1 = '0;
   logic [31:0] m_srr0 = '0;

   always #5 clk = ~clk;

   exc_entry_unit uut (
      .clk(clk), .rst_n(rst_n), .req_sysrst(req_sysrst), .req_mcheck(req_mcheck),
      .ins_valid(ins_valid), .flag_align(flag_align), .flag_fp(flag_fp),
      .req_ext(req_ext), .req_dec(req_dec), .cur_pc(cur_pc), .ret_pulse(ret_pulse),
      .msr_load(msr_load), .msr_load_val(msr_load_val), .redirect(redirect),
      .redirect_pc(redirect_pc), .cause_idx(cause_idx), .msr_q(msr_q),
      .srr0_q(srr0_q), .srr1_q(srr1_q)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, compare, then advance the model at posedge
   task automatic step(input bit rs, input bit mc, input bit iv, input bit al, input bit fp,
                       input bit ex, input bit dc, input bit rt, input bit ld,
                       input logic [7:0] lv, input logic [31:0] pc);
      int slot;
      bit exc_hit, ret_hit;
      logic [31:0] exp_pc;
      @(negedge clk);
      req_sysrst = rs; req_mcheck = mc; ins_valid = iv; flag_align = al; flag_fp = fp;
      req_ext = ex; req_dec = dc; ret_pulse = rt; msr_load = ld; msr_load_val = lv; cur_pc = pc;
      #1;
      slot = 0;
      if (rs)                  slot = 1;
      else if (mc)             slot = 2;
      else if (iv && al)       slot = 6;
      else if (iv && fp)       slot = 8;
      else if (m_msr[0] && ex) slot = 5;
      else if (m_msr[0] && dc) slot = 9;
      exc_hit = (slot != 0);
      ret_hit = rt && !exc_hit;
      if (exc_hit)      exp_pc = (m_msr[2] ? 32'hFFF0_0000 : 32'h0) + slot * 256;
      else if (ret_hit) exp_pc = m_srr0;
      else              exp_pc = 32'h0;
      chk(32'(redirect), 32'(exc_hit || ret_hit), "R2", "redirect");
      chk(32'(cause_idx), 32'(slot), exc_hit ? "R2" : "R9", "cause_idx");
      chk(redirect_pc, exp_pc, exc_hit ? (m_msr[2] ? "R6" : "R5") : (ret_hit ? "R9" : "R10"), "redirect_pc");
      if (exc_hit) begin
         m_srr0 = pc; m_srr1 = m_msr; m_msr = m_msr & 8'hFC;
      end else if (ret_hit) begin
         m_msr = m_srr1;
      end else if (ld) begin
         m_msr = lv;
      end
      @(posedge clk);
      #1;
      chk(32'(msr_q), 32'(m_msr), exc_hit ? "R8" : (ret_hit ? "R9" : "R10"), "msr_q");
      chk(srr0_q, m_srr0, "R7", "srr0_q");
      chk(32'(srr1_q), 32'(m_srr1), "R7", "srr1_q");
   endtask

   task automatic idle();
      step(0,0,0,0,0,0,0,0,0,8'h00,32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk(32'(msr_q), 32'h0, "R1", "msr_q");
      chk(srr0_q, 32'h0, "R1", "srr0_q");
      chk(32'(srr1_q), 32'h0, "R1", "srr1_q");
      chk(32'(redirect), 32'h0, "R1", "redirect");
      chk(32'(cause_idx), 32'h0, "R1", "cause_idx");
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R4: masked ext/dec ignored while enable clear
      step(0,0,0,0,0,1,1,0,0,8'h00,32'h1000);
      // R3: sync flags without ins_valid ignored
      step(0,0,0,1,1,0,0,0,0,8'h00,32'h1004);
      // R10: load msr (enable, user, high table, recoverable)
      step(0,0,0,0,0,0,0,0,1,8'h27,32'h1008);
      // R4/R6: ext taken from high table, saves state
      step(0,0,0,0,0,1,1,0,0,8'h00,32'h2000);
      // R9: return restores
      step(0,0,0,0,0,0,0,1,0,8'h00,32'h2004);
      // R4: decrementer alone
      step(0,0,0,0,0,0,1,0,0,8'h00,32'h3000);
      step(0,0,0,0,0,0,0,1,0,8'h00,32'h0);
      // R2: full pile-up, then peel off sources
      step(1,1,1,1,1,1,1,1,1,8'hFF,32'h4000);
      step(0,1,1,1,1,1,1,0,0,8'h00,32'h4004);
      step(0,0,1,1,1,1,1,0,0,8'h00,32'h4008);
      step(0,0,1,0,1,1,1,0,0,8'h00,32'h400C);
      // R4: machine check unmasked with enable clear
      step(0,1,0,0,0,0,0,0,0,8'h00,32'h5000);
      // R10: exception beats return and load; return beats load
      step(0,0,1,1,0,0,0,1,1,8'h55,32'h6000);
      step(0,0,0,0,0,0,0,1,1,8'hAA,32'h6004);
      step(0,0,0,0,0,0,0,0,1,8'h05,32'h6008);
      step(0,0,0,0,0,1,0,0,0,8'h00,32'h7000);
      idle();
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 40) == 0, ($urandom % 30) == 0, $urandom % 2, ($urandom % 5) == 0,
              ($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
              ($urandom % 4) == 0, ($urandom % 3) == 0, 8'($urandom), {$urandom} & 32'hFFFF_FFFC);
      end
      idle();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule